// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

A clocked static RAM of 36-bit words, each word split into four 9-bit lanes (eight data bits plus one parity bit per lane). Addresses are taken in on a rising clock edge when either of two active-low load strobes asks for it. One strobe loads unconditionally. The other acts only while the chip enable is low. After a load, a 2-bit burst counter steps through the four words of an aligned group, in linear or interleaved order, each time the step input is low at a clock edge.

Writes happen at a clock edge to the current burst address, using the data and enables sampled at that edge. A whole-word write input overrides the per-lane controls. Per-lane enables take effect only through a lane-write gate. Reads are not registered: the word at the current burst address reaches the data output in the same cycle. A separate drive-enable output stands in for the tri-state control. A sleep input freezes all state and keeps the array contents.

Top module: `sync_burst_sram`

## Requirements
- R1: When `load_ext_n_i` is low at a rising edge, the address on `addr_i` becomes the current burst address, the counter restarts at 0, and the selection state is resampled, whatever the chip enable is.
- R2: When `load_host_n_i` is low at a rising edge, it loads the address (as R1) only if `en_n_i` is also low; with `en_n_i` high it has no effect.
- R3: The selection sampled at a load is true only when `en_n_i` is low, `sel_hi_i` is high and `sel_lo_n_i` is low. While deselected, no write reaches the array and `dout_en_o` stays low.
- R4: With no load, `step_n_i` low at an edge advances the 2-bit burst count by one, wrapping after four beats, and `step_n_i` high holds the address. Address bits above bit 1 never change during a burst.
- R5: With `interleave_i` low, the low two address bits are (loaded bits + count) mod 4. With it high, they are loaded bits XOR count.
- R6: When `wr_all_n_i` is low at an edge, all four lanes of the current word are written, whatever the lane controls are.
- R7: When `lane_gate_n_i` is low, each low bit n of `lane_wr_n_i` writes data bits 8n..8n+7 and parity bit 32+n. When the gate is high, `lane_wr_n_i` is ignored.
- R8: A write stores `din_i` as sampled at the edge into the word at the current burst address before that edge's address update. No write takes place at an edge where the host strobe loads.
- R9: `dout_o` shows the stored word at the current burst address combinationally, with no register stage.
- R10: `dout_en_o` is high only when `oe_n_i` is low, the device is selected, no write is requested on the inputs, and `sleep_i` is low.
- R11: While `sleep_i` is high, no address, count, selection or array state changes at clock edges.
- R12: After `rst_ni` the burst address is 0, the count is 0 and the device is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Address to load |
| load_ext_n_i | input | 1 | Unconditional address load strobe, active low |
| load_host_n_i | input | 1 | Address load strobe gated by chip enable, active low |
| en_n_i | input | 1 | Chip enable, active low |
| sel_hi_i | input | 1 | Chip select, active high |
| sel_lo_n_i | input | 1 | Chip select, active low |
| step_n_i | input | 1 | Burst advance, active low |
| interleave_i | input | 1 | Burst order: 1 interleaved, 0 linear; static during a burst |
| wr_all_n_i | input | 1 | Whole-word write, active low |
| lane_gate_n_i | input | 1 | Gate for per-lane write enables, active low |
| lane_wr_n_i | input | 4 | Per-lane write enables, active low |
| din_i | input | 36 | Write data, lane n = {bit 32+n, bits 8n+7..8n} |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Freeze all state while high |
| dout_o | output | 36 | Flow-through read data |
| dout_en_o | output | 1 | Output drive enable |

## Verification
Bursts start from an unaligned address so that the linear run (9,10,11,8) and the interleaved run (10,11,8,9) give different word orders from the same data. A fifth beat checks the wrap. Lane writes with a sparse mask, a gated-off mask and a whole-word write that carries a contradicting mask show which lanes change and which control wins. Host-strobe loads with the enable high and low, deselected loads, sleep cycles carrying load and write requests, and a raised output enable each show whether an input was ignored, through the address and data seen on the next read.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int LANE_W = BYTE_W + 1;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [1:0] beat_t;

  function automatic beat_t burst_low(beat_t base, beat_t cnt, logic ilv);
    return ilv ? (base ^ cnt) : beat_t'(base + cnt);
  endfunction
endpackage

// File: rtl/sbsram_addr_seq.sv
module sbsram_addr_seq
  import sbsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [AW-1:0] addr_i,
  input  logic          load_ext_n_i,
  input  logic          load_host_n_i,
  input  logic          en_n_i,
  input  logic          sel_hi_i,
  input  logic          sel_lo_n_i,
  input  logic          step_n_i,
  input  logic          interleave_i,
  output logic [AW-1:0] cur_addr_o,
  output logic          sel_o,
  output logic          host_ld_o
);
  logic [AW-1:0] base_q;
  beat_t         cnt_q;
  logic          sel_q;
  logic          ld;

  assign host_ld_o = !load_host_n_i && !en_n_i;
  assign ld        = !load_ext_n_i || host_ld_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else if (run_i) begin
      if (ld) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        sel_q  <= !en_n_i && sel_hi_i && !sel_lo_n_i;
      end else if (!step_n_i) begin
        cnt_q <= cnt_q + beat_t'(1);
      end
    end
  end

  assign cur_addr_o = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q, interleave_i)};
  assign sel_o      = sel_q;
endmodule

// File: rtl/sbsram_wr_dec.sv
module sbsram_wr_dec
  import sbsram_pkg::*;
(
  input  logic             wr_all_n_i,
  input  logic             lane_gate_n_i,
  input  logic [LANES-1:0] lane_wr_n_i,
  output logic [LANES-1:0] lane_we_o,
  output logic             wr_req_o
);
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign lane_we_o[n] = !wr_all_n_i || (!lane_gate_n_i && !lane_wr_n_i[n]);
  end
  assign wr_req_o = |lane_we_o;
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] wlane;
    assign wlane = {wdata_i[LANES*BYTE_W+n], wdata_i[n*BYTE_W +: BYTE_W]};

    always_ff @(posedge clk_i) begin
      if (we_i && lane_we_i[n]) mem[addr_i] <= wlane;
    end

    assign rdata_o[n*BYTE_W +: BYTE_W]  = mem[addr_i][BYTE_W-1:0];
    assign rdata_o[LANES*BYTE_W+n]      = mem[addr_i][BYTE_W];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              load_ext_n_i,
  input  logic              load_host_n_i,
  input  logic              en_n_i,
  input  logic              sel_hi_i,
  input  logic              sel_lo_n_i,
  input  logic              step_n_i,
  input  logic              interleave_i,
  input  logic              wr_all_n_i,
  input  logic              lane_gate_n_i,
  input  logic [LANES-1:0]  lane_wr_n_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              dout_en_o
);
  logic [AW-1:0]    cur_addr;
  logic             sel;
  logic             host_ld;
  logic [LANES-1:0] lane_we;
  logic             wr_req;
  logic             we;

  sbsram_addr_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .run_i        (!sleep_i),
    .addr_i, .load_ext_n_i, .load_host_n_i, .en_n_i, .sel_hi_i, .sel_lo_n_i,
    .step_n_i, .interleave_i,
    .cur_addr_o   (cur_addr),
    .sel_o        (sel),
    .host_ld_o    (host_ld)
  );

  sbsram_wr_dec u_dec (
    .wr_all_n_i, .lane_gate_n_i, .lane_wr_n_i,
    .lane_we_o (lane_we),
    .wr_req_o  (wr_req)
  );

  // host-strobe load edge starts a read; writes wait for the next edge
  assign we = !sleep_i && sel && wr_req && !host_ld;

  sbsram_array #(.DEPTH(DEPTH)) u_mem (
    .clk_i,
    .we_i      (we),
    .lane_we_i (lane_we),
    .addr_i    (cur_addr),
    .wdata_i   (din_i),
    .rdata_o   (dout_o)
  );

  assign dout_en_o = !oe_n_i && sel && !wr_req && !sleep_i;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sleep_i,
  input logic          load_ext_n_i,
  input logic          load_host_n_i,
  input logic          en_n_i,
  input logic          step_n_i,
  input logic          wr_all_n_i,
  input logic          oe_n_i,
  input logic [AW-1:0] addr_i,
  input logic [AW-1:0] cur_addr,
  input logic          sel,
  input logic          dout_en_o
);
  assert_ext_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !load_ext_n_i) |=> (cur_addr == $past(addr_i)));

  assert_host_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && load_ext_n_i && !load_host_n_i && en_n_i && step_n_i) |=> $stable(cur_addr));

  assert_desel_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> !dout_en_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && load_ext_n_i && load_host_n_i && step_n_i) |=> $stable(cur_addr));

  assert_step_in_group_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && load_ext_n_i && load_host_n_i && !step_n_i)
      |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  assert_full_write_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_all_n_i |-> !dout_en_o);

  assert_oe_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !dout_en_o);

  assert_freeze_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(cur_addr) && $stable(sel)));
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .sleep_i, .load_ext_n_i, .load_host_n_i, .en_n_i,
  .step_n_i, .wr_all_n_i, .oe_n_i, .addr_i,
  .cur_addr (cur_addr),
  .sel      (sel),
  .dout_en_o
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ld_ext_n = 1'b1, ld_host_n = 1'b1, en_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic          step_n = 1'b1, ilv = 1'b0, wall_n = 1'b1, gate_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]    lane_n = 4'hf;
  logic [35:0]   din = '0;
  logic [35:0]   dout;
  logic          dout_en;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [35:0] data;
    logic        en;
    logic        chk_data;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // bench model, derived from the requirements
  logic [35:0]   ref_mem [DEPTH];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_sel = 1'b0;

  always #5 clk = ~clk;

  sync_burst_sram #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .load_ext_n_i(ld_ext_n), .load_host_n_i(ld_host_n), .en_n_i(en_n),
    .sel_hi_i(sel_hi), .sel_lo_n_i(sel_lo_n), .step_n_i(step_n), .interleave_i(ilv),
    .wr_all_n_i(wall_n), .lane_gate_n_i(gate_n), .lane_wr_n_i(lane_n), .din_i(din),
    .oe_n_i(oe_n), .sleep_i(sleep), .dout_o(dout), .dout_en_o(dout_en)
  );

  function automatic logic [AW-1:0] m_cur();
    logic [1:0] lo;
    lo = ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  function automatic logic [3:0] m_mask();
    if (!wall_n) return 4'hf;
    if (!gate_n) return ~lane_n;
    return 4'h0;
  endfunction

  task automatic idle();
    ld_ext_n = 1; ld_host_n = 1; en_n = 0; sel_hi = 1; sel_lo_n = 0;
    step_n = 1; wall_n = 1; gate_n = 1; lane_n = 4'hf; oe_n = 0; sleep = 0;
  endtask

  // inputs already set; push the expectation for this cycle, then let the edge pass
  task automatic tick(string tag);
    exp_t e;
    logic [3:0] mk;
    logic host_ld;
    @(negedge clk);
    mk = m_mask();
    e.en = !oe_n && m_sel && (mk == 0) && !sleep;
    e.data = ref_mem[m_cur()];
    e.chk_data = e.en;
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    if (!sleep) begin
      host_ld = !ld_host_n && !en_n;
      if (m_sel && mk != 0 && !host_ld) begin
        for (int n = 0; n < 4; n++)
          if (mk[n]) begin
            ref_mem[m_cur()][8*n +: 8] = din[8*n +: 8];
            ref_mem[m_cur()][32+n]     = din[32+n];
          end
      end
      if (!ld_ext_n || host_ld) begin
        m_base = addr; m_cnt = 0; m_sel = !en_n && sel_hi && !sel_lo_n;
      end else if (!step_n) m_cnt = m_cnt + 2'd1;
    end
  endtask

  // monitor: compares once the cycle's inputs have settled
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (dout_en !== e.en || (e.chk_data && dout !== e.data)) begin
          n_bad++;
          $display("FAIL %s: en=%b dout=%h expected en=%b dout=%h",
                   e.tag, dout_en, dout, e.en, e.data);
        end
      end
    end
  end

  task automatic load_ext(logic [AW-1:0] a, string tag);
    idle(); ld_ext_n = 0; addr = a; tick(tag);
  endtask

  task automatic read_beats(int k, string tag);
    for (int i = 0; i < k; i++) begin idle(); step_n = 0; tick(tag); end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    tick("R12 deselected after reset");

    // fill words 8..11 with full writes, linear burst
    ilv = 0;
    load_ext(6'd8, "R1 load 8");
    for (int i = 0; i < 4; i++) begin
      idle(); wall_n = 0; step_n = 0; din = {4'(i + 5), 32'hA0B0C000 + 32'(i)};
      tick("R6 R10 full write burst, outputs off");
    end
    // fill 12..15 by lane gate with all lanes
    load_ext(6'd12, "R1 load 12");
    for (int i = 0; i < 4; i++) begin
      idle(); gate_n = 0; lane_n = 4'h0; step_n = 0; din = {4'(i), 32'h1234_0000 + 32'(i)};
      tick("R7 lane burst write");
    end

    load_ext(6'd9, "R1 load 9");
    read_beats(5, "R4 R5 R9 linear 9,10,11,8 wrap");

    ilv = 1;
    load_ext(6'd10, "R1 load 10 interleaved");
    read_beats(4, "R5 R9 interleaved 10,11,8,9");
    load_ext(6'd13, "R1 load 13 interleaved");
    read_beats(4, "R5 interleaved 13,12,15,14");
    ilv = 0;

    // sparse lane write on word 8
    load_ext(6'd8, "R1 load 8");
    idle(); gate_n = 0; lane_n = 4'b1010; din = 36'hF_FFFF_FFFF; tick("R7 lanes 0 and 2");
    tick("R7 readback sparse lanes");
    // gate off: mask ignored
    idle(); gate_n = 1; lane_n = 4'b0000; din = 36'h0_0000_0000; tick("R7 gate high, drives");
    tick("R7 readback after gated-off mask");
    // full write overrides a contradicting mask
    idle(); wall_n = 0; gate_n = 0; lane_n = 4'hf; din = 36'h5_5AA5_5AA5; tick("R6 override");
    tick("R6 readback full word");

    // host strobe with enable high: ignored
    idle(); en_n = 1; ld_host_n = 0; addr = 6'd14; tick("R2 host strobe gated");
    idle(); tick("R2 address unchanged");
    // host strobe with enable low loads, write on same edge blocked
    idle(); ld_host_n = 0; addr = 6'd15; wall_n = 0; din = 36'h0; tick("R8 host load with write");
    idle(); tick("R2 R8 word 8 untouched, now at 15");
    idle(); wall_n = 0; din = 36'h9_8765_4321; tick("R8 write at 15");
    idle(); tick("R8 R9 readback 15");

    // deselected load
    idle(); ld_ext_n = 0; addr = 6'd9; sel_hi = 0; tick("R3 deselecting load");
    idle(); wall_n = 0; din = 36'h0; tick("R3 write while deselected");
    idle(); sel_lo_n = 1; ld_ext_n = 0; addr = 6'd9; tick("R3 second deselecting form");
    load_ext(6'd9, "R3 reselect");
    tick("R3 word 9 unchanged");

    // sleep freezes everything
    idle(); sleep = 1; ld_ext_n = 0; addr = 6'd12; wall_n = 0; din = 36'h0; tick("R11 sleep");
    idle(); sleep = 1; step_n = 0; tick("R11 sleep step");
    idle(); tick("R11 same address and data after sleep");

    // output enable
    idle(); oe_n = 1; tick("R10 oe high");
    idle(); gate_n = 0; lane_n = 4'b1110; oe_n = 0; din = 36'h0_0000_00EE; tick("R10 lane write off");
    idle(); tick("R10 R7 lane 0 written");

    @(negedge clk); #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: en=%b dout=%h expected run to end", dout_en, dout);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule